// File: doc/BRIEF.md
# SPI Status Flag Front End

This block sits between a CPU register bus and the shift engine of a serial peripheral interface. It holds the received byte, passes bytes to be sent on to the shift engine, and keeps three status flags: receive-full, transmit-empty and mode-fault. The flags are set by event pulses from the shift engine. Software clears a flag only with a two-step sequence. First it reads the status register while the flag is 1, which arms that flag. Then it makes the matching access to another register. A byte written to the data register is kept only if transmit-empty was armed this way. Otherwise the write is dropped without any sign.

The bus has four registers, selected by a 2-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | control A | bit 0 selects master operation, bit 1 enables the transmit interrupt |
| 1 | control B | bit 0 enables mode-fault detection |
| 2 | status | the three flags; read-only |
| 3 | data | reads return the held receive byte; writes offer a transmit byte |

Read data is combinational from the current address. The interrupt request is a single level output.

Top module: `spi_sf_top`

## Requirements
- R1: A status read at address 2 returns receive-full in bit 7, transmit-empty in bit 5 and mode-fault in bit 4. Bits 6 and 3..0 read 0.
- R2: After reset, status reads 0x20, both control registers read 0, irq is 0 and tx_valid is 0.
- R3: A write to the status address changes no flag and does not complete any clearing sequence.
- R4: A rx_done pulse stores rx_byte, which later data reads (address 3) return, and sets receive-full on the next edge.
- R5: Receive-full clears only when a data read follows a status read that returned it as 1. A data read without that status read leaves it set.
- R6: A data write after a status read that returned transmit-empty as 1 clears transmit-empty. It also places the byte on tx_byte with tx_valid high for exactly the next cycle.
- R7: A data write without a prior status read that returned transmit-empty as 1 is dropped. tx_valid stays 0 and transmit-empty stays 1.
- R8: A tx_taken pulse sets transmit-empty again.
- R9: A ss_low pulse sets mode-fault only while control A bit 0 and control B bit 0 are both 1.
- R10: Mode-fault clears when a write to control A follows a status read that returned it as 1.
- R11: When a set event and a completing access happen in the same cycle, the flag stays 1.
- R12: irq is 1 while receive-full or mode-fault is 1, or while transmit-empty is 1 and control A bit 1 is 1.
- R13: A completing access disarms its flag. Once the flag is set again, a new status read is needed before it can be cleared.
- R14: Reads of control A and control B return the stored bits in their low positions, with 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| rx_done | input | 1 | Shift engine has a received byte |
| rx_byte | input | DATA_W | Received byte, valid with rx_done |
| tx_taken | input | 1 | Shift engine has taken the transmit byte |
| ss_low | input | 1 | Slave-select was sampled low |
| tx_byte | output | DATA_W | Accepted transmit byte |
| tx_valid | output | 1 | One-cycle pulse when tx_byte is newly accepted |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are those where an arm bit and a flag disagree. Examples are a flag set again in the same cycle as its completing access, and a flag that is set but no longer armed. Neither can be seen at the status register. The stimulus drives a data read together with a rx_done pulse in one cycle, and a data write together with tx_taken in one cycle. It then issues a second data access with no status read in between. The flag must still read 1 afterwards, which shows that the arm was used up while the flag stayed set.

// File: rtl/spi_sf_pkg.sv
package spi_sf_pkg;

  typedef enum logic [1:0] {
    SF_CTRLA = 2'd0,
    SF_CTRLB = 2'd1,
    SF_STAT  = 2'd2,
    SF_DATA  = 2'd3
  } sf_addr_e;

  localparam int FLG_RX  = 0;
  localparam int FLG_TX  = 1;
  localparam int FLG_MF  = 2;
  localparam int FLG_NUM = 3;

  localparam int STAT_RX_POS = 7;
  localparam int STAT_TX_POS = 5;
  localparam int STAT_MF_POS = 4;

  localparam int CA_MASTER_POS = 0;
  localparam int CA_TXIE_POS   = 1;
  localparam int CB_MFEN_POS   = 0;
  localparam int CA_W = 2;
  localparam int CB_W = 1;

  localparam logic [FLG_NUM-1:0] FLG_RST = 3'b010;

endpackage

// File: rtl/spi_sf_flag.sv
module spi_sf_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic arm_i,
  input  logic done_i,
  output logic flag_o,
  output logic armed_o
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic upd_en;

  assign upd_en = set_i | arm_i | done_i;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (done_i) begin
      arm_d = 1'b0;
      if (arm_q) flag_d = 1'b0;
    end
    if (arm_i) arm_d  = 1'b1;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;

endmodule

// File: rtl/spi_sf_ctrl.sv
module spi_sf_ctrl #(
  parameter int CA_W = 2,
  parameter int CB_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_a,
  input  logic            wr_b,
  input  logic [CA_W-1:0] wdata_a,
  input  logic [CB_W-1:0] wdata_b,
  output logic [CA_W-1:0] ctrl_a,
  output logic [CB_W-1:0] ctrl_b
);

  logic [CA_W-1:0] a_q, a_d;
  logic [CB_W-1:0] b_q, b_d;

  always_comb begin
    a_d = wr_a ? wdata_a : a_q;
    b_d = wr_b ? wdata_b : b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (wr_a) begin
      a_q <= a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (wr_b) begin
      b_q <= b_d;
    end
  end

  assign ctrl_a = a_q;
  assign ctrl_b = b_q;

endmodule

// File: rtl/spi_sf_data.sv
module spi_sf_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_in,
  input  logic              tx_accept,
  input  logic [DATA_W-1:0] tx_in,
  output logic [DATA_W-1:0] rx_hold,
  output logic [DATA_W-1:0] tx_out,
  output logic              tx_pulse
);

  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              pulse_q, pulse_d;

  always_comb begin
    rx_d    = rx_load   ? rx_in : rx_q;
    tx_d    = tx_accept ? tx_in : tx_q;
    pulse_d = tx_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_load) begin
      rx_q <= rx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_accept) begin
      tx_q <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign rx_hold  = rx_q;
  assign tx_out   = tx_q;
  assign tx_pulse = pulse_q;

endmodule

// File: rtl/spi_sf_top.sv
module spi_sf_top
  import spi_sf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_taken,
  input  logic              ss_low,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid,
  output logic              irq
);

  // reset: asserted at once, released two edges later
  logic rst_meta_q, core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  // bus decode
  sf_addr_e sel;
  logic     rd_stat, rd_data, wr_data, wr_ca, wr_cb;

  assign sel     = sf_addr_e'(bus_addr);
  assign rd_stat = bus_rd & (sel == SF_STAT);
  assign rd_data = bus_rd & (sel == SF_DATA);
  assign wr_data = bus_wr & (sel == SF_DATA);
  assign wr_ca   = bus_wr & (sel == SF_CTRLA);
  assign wr_cb   = bus_wr & (sel == SF_CTRLB);

  // control registers
  logic [CA_W-1:0] ctrl_a;
  logic [CB_W-1:0] ctrl_b;

  spi_sf_ctrl #(.CA_W(CA_W), .CB_W(CB_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_a    (wr_ca),
    .wr_b    (wr_cb),
    .wdata_a (bus_wdata[CA_W-1:0]),
    .wdata_b (bus_wdata[CB_W-1:0]),
    .ctrl_a  (ctrl_a),
    .ctrl_b  (ctrl_b)
  );

  // flag events
  logic [FLG_NUM-1:0] flag_set, flag_done, flag_arm;
  logic [FLG_NUM-1:0] flag_q, flag_armed;

  always_comb begin
    flag_set            = '0;
    flag_done           = '0;
    flag_set[FLG_RX]    = rx_done;
    flag_set[FLG_TX]    = tx_taken;
    flag_set[FLG_MF]    = ss_low & ctrl_a[CA_MASTER_POS] & ctrl_b[CB_MFEN_POS];
    flag_done[FLG_RX]   = rd_data;
    flag_done[FLG_TX]   = wr_data;
    flag_done[FLG_MF]   = wr_ca;
  end

  assign flag_arm = {FLG_NUM{rd_stat}} & flag_q;

  for (genvar g = 0; g < FLG_NUM; g++) begin : g_flag
    spi_sf_flag #(.RST_VAL(FLG_RST[g])) u_flag (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .set_i   (flag_set[g]),
      .arm_i   (flag_arm[g]),
      .done_i  (flag_done[g]),
      .flag_o  (flag_q[g]),
      .armed_o (flag_armed[g])
    );
  end

  logic unused_armed;
  assign unused_armed = flag_armed[FLG_RX] ^ flag_armed[FLG_MF];

  // data path
  logic              tx_accept;
  logic [DATA_W-1:0] rx_hold;

  assign tx_accept = wr_data & flag_armed[FLG_TX];

  spi_sf_data #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .rx_load   (rx_done),
    .rx_in     (rx_byte),
    .tx_accept (tx_accept),
    .tx_in     (bus_wdata),
    .rx_hold   (rx_hold),
    .tx_out    (tx_byte),
    .tx_pulse  (tx_valid)
  );

  // read mux
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word              = '0;
    stat_word[STAT_RX_POS] = flag_q[FLG_RX];
    stat_word[STAT_TX_POS] = flag_q[FLG_TX];
    stat_word[STAT_MF_POS] = flag_q[FLG_MF];
  end

  always_comb begin
    unique case (sel)
      SF_CTRLA: bus_rdata = DATA_W'(ctrl_a);
      SF_CTRLB: bus_rdata = DATA_W'(ctrl_b);
      SF_STAT:  bus_rdata = stat_word;
      SF_DATA:  bus_rdata = rx_hold;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q[FLG_RX] | flag_q[FLG_MF] |
               (flag_q[FLG_TX] & ctrl_a[CA_TXIE_POS]);

endmodule

// File: rtl/spi_sf_chk.sv
module spi_sf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_done,
  input logic              tx_taken,
  input logic              ss_low,
  input logic              tx_valid,
  input logic              irq,
  input logic [2:0]        flags
);

  AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2) |-> (bus_rdata[6] == 1'b0 && bus_rdata[3:0] == 4'd0)); // R1

  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> flags[0]); // R4

  AST_RX_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(bus_rd && bus_addr == 2'd3)); // R5

  AST_TX_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(bus_wr && bus_addr == 2'd3)); // R6

  AST_TXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid); // R6

  AST_TXV_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == 2'd3 && flags[1])); // R7

  AST_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> flags[1]); // R8

  AST_MF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(ss_low)); // R9

  AST_MF_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(bus_wr && bus_addr == 2'd0)); // R10

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] || flags[2]) |-> irq); // R12

endmodule

bind spi_sf_top spi_sf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .rx_done   (rx_done),
  .tx_taken  (tx_taken),
  .ss_low    (ss_low),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .flags     (flag_q)
);

// File: tb/spi_sf_top_tb.sv
module spi_sf_top_tb;

  localparam int CLK_P = 10;

  localparam logic [2:0] OP_IDLE = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2,
                         OP_RX = 3'd3, OP_TAKE = 3'd4, OP_SS = 3'd5;
  localparam logic [1:0] A_CA = 2'd0, A_CB = 2'd1, A_ST = 2'd2, A_DT = 2'd3;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       irq;
    logic       txv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   A_DT, 8'hA5, 8'h00, 1'b0, 1'b0, 4'd7 },  // R7 unarmed write
    '{OP_IDLE, A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd7 },  // R7 no pulse
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd7 },  // R7 flag kept, R1
    '{OP_WR,   A_ST, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd3 },  // R3 status write
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd3 },  // R3 unchanged
    '{OP_WR,   A_DT, 8'h3C, 8'h00, 1'b0, 1'b0, 4'd6 },  // R6 armed write
    '{OP_IDLE, A_CA, 8'h00, 8'h00, 1'b0, 1'b1, 4'd6 },  // R6 pulse
    '{OP_RD,   A_ST, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6 },  // R6 cleared
    '{OP_TAKE, A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8 },  // R8
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd8 },  // R8 set again
    '{OP_RX,   A_CA, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd4 },  // R4
    '{OP_RD,   A_DT, 8'h00, 8'h5A, 1'b1, 1'b0, 4'd4 },  // R4 byte, R5 unarmed read
    '{OP_RD,   A_ST, 8'h00, 8'hA0, 1'b1, 1'b0, 4'd5 },  // R5 still set
    '{OP_RD,   A_DT, 8'h00, 8'h5A, 1'b1, 1'b0, 4'd5 },  // R5 completes
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd5 },  // R5 cleared
    '{OP_WR,   A_CA, 8'h02, 8'h00, 1'b0, 1'b0, 4'd12},  // R12 enable tx irq
    '{OP_IDLE, A_CA, 8'h00, 8'h00, 1'b1, 1'b0, 4'd12},  // R12
    '{OP_WR,   A_CA, 8'h01, 8'h00, 1'b1, 1'b0, 4'd12},  // R12 master, irq off
    '{OP_SS,   A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd9 },  // R9 detect off
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd9 },  // R9 no fault
    '{OP_WR,   A_CB, 8'h01, 8'h00, 1'b0, 1'b0, 4'd9 },  // R9 detect on
    '{OP_SS,   A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd9 },  // R9
    '{OP_RD,   A_ST, 8'h00, 8'h30, 1'b1, 1'b0, 4'd9 },  // R9 fault set, R12
    '{OP_WR,   A_CA, 8'h01, 8'h00, 1'b1, 1'b0, 4'd10},  // R10 completes
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd10},  // R10 cleared
    '{OP_RD,   A_CA, 8'h00, 8'h01, 1'b0, 1'b0, 4'd14},  // R14
    '{OP_RD,   A_CB, 8'h00, 8'h01, 1'b0, 1'b0, 4'd14},  // R14
    '{OP_WR,   A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd9 },  // R9 master off
    '{OP_SS,   A_CA, 8'h00, 8'h00, 1'b0, 1'b0, 4'd9 },  // R9
    '{OP_RD,   A_ST, 8'h00, 8'h20, 1'b0, 1'b0, 4'd9 }   // R9 no fault
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_done, tx_taken, ss_low;
  logic [7:0] rx_byte, tx_byte;
  logic       tx_valid, irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_sf_top #(.DATA_W(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .tx_taken  (tx_taken),
    .ss_low    (ss_low),
    .tx_byte   (tx_byte),
    .tx_valid  (tx_valid),
    .irq       (irq)
  );

  task automatic check(input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; rx_done = 1'b0; tx_taken = 1'b0; ss_low = 1'b0;
    bus_addr = a; bus_wdata = d; rx_byte = d;
    case (op)
      OP_RD:   bus_rd   = 1'b1;
      OP_WR:   bus_wr   = 1'b1;
      OP_RX:   rx_done  = 1'b1;
      OP_TAKE: tx_taken = 1'b1;
      OP_SS:   ss_low   = 1'b1;
      default: ;
    endcase
    #(CLK_P/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; rx_done = 1'b0; tx_taken = 1'b0; ss_low = 1'b0;
    bus_addr = 2'd0; bus_wdata = 8'h00; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R2 reset state, without a status read so that nothing is armed
    step(OP_IDLE, A_CA, 8'h00);
    check(2, "irq after reset", {7'd0, irq}, 8'h00);
    check(2, "tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    step(OP_RD, A_CA, 8'h00);
    check(2, "ctrl A after reset", bus_rdata, 8'h00);
    step(OP_RD, A_CB, 8'h00);
    check(2, "ctrl B after reset", bus_rdata, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].addr, VECS[i].data);
      if (VECS[i].op == OP_RD)
        check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), bus_rdata, VECS[i].exp);
      check(int'(VECS[i].req), $sformatf("vec %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].irq});
      check(int'(VECS[i].req), $sformatf("vec %0d tx_valid", i), {7'd0, tx_valid}, {7'd0, VECS[i].txv});
    end

    // R11 receive set against a completing read in the same cycle, then R13
    step(OP_RX, A_CA, 8'h11);
    step(OP_RD, A_ST, 8'h00);
    check(4, "rx flag set", bus_rdata, 8'hA0);
    step(OP_RD, A_DT, 8'h00);
    rx_done = 1'b1; rx_byte = 8'h22;
    check(4, "old rx byte", bus_rdata, 8'h11);
    step(OP_RD, A_DT, 8'h00);
    check(4, "new rx byte", bus_rdata, 8'h22);
    step(OP_RD, A_ST, 8'h00);
    check(11, "rx set wins, R13 arm used up", bus_rdata, 8'hA0);
    step(OP_RD, A_DT, 8'h00);
    step(OP_RD, A_ST, 8'h00);
    check(13, "rx cleared after fresh arm", bus_rdata, 8'h20);

    // R6 byte value and R11 transmit set against a completing write
    step(OP_RD, A_ST, 8'h00);
    step(OP_WR, A_DT, 8'hC3);
    tx_taken = 1'b1;
    step(OP_IDLE, A_CA, 8'h00);
    check(6, "tx_valid after armed write", {7'd0, tx_valid}, 8'h01);
    check(6, "tx_byte", tx_byte, 8'hC3);
    step(OP_RD, A_ST, 8'h00);
    check(11, "tx set wins", bus_rdata, 8'h20);
    check(6, "tx_valid one cycle", {7'd0, tx_valid}, 8'h00);

    // R2 reset in mid-run restores defaults
    step(OP_WR, A_CA, 8'h03);
    step(OP_RX, A_CA, 8'h77);
    do_reset();
    step(OP_RD, A_CA, 8'h00);
    check(2, "ctrl A after second reset", bus_rdata, 8'h00);
    check(2, "irq after second reset", {7'd0, irq}, 8'h00);
    step(OP_RD, A_ST, 8'h00);
    check(2, "status after second reset", bus_rdata, 8'h20);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule